// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the command register a local processor uses to send an interrupt message to other processors. Software reaches it through a narrow 32-bit register port at byte offsets. It first writes the destination word, then writes the command word. The command-word write builds a message record and presents it on a valid/ready output. A busy bit in the command word reads back as 1 while the message waits for the fabric to take it.

A second path takes the whole 64-bit command in one write at a fixed register index. This path carries a full 32-bit destination for the wide addressing mode. Any launch attempted while a message is still in flight is dropped, and a one-cycle reject pulse reports it.

The message record holds these fields:
- the vector
- the delivery mode
- the destination mode
- the level
- the trigger mode
- the shorthand
- the destination
- for start-up messages, the start address derived from the vector

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, msg_valid and busy_reject are 0, and reads of the command word (byte offset 0x300) and the destination word (byte offset 0x310) return 0.
- R2: A narrow write to offset 0x300 while idle sets msg_valid from the next cycle. The message fields are taken from the written word:
  - msg_vector from bits [7:0]
  - msg_dlv from [10:8]
  - msg_logical from [11]
  - msg_level from [14]
  - msg_trig from [15]
  - msg_shorthand from [19:18]
  - msg_dest from bits [31:24] of the destination word, zero-extended to 32 bits.
- R3: Bit 12 of a command-word read equals msg_valid. msg_valid clears in the cycle after an edge where msg_valid and msg_ready are both 1.
- R4: While msg_valid is 1 and msg_ready is 0, every message field holds its value, even if the destination word is rewritten. The rewritten destination word still reads back at offset 0x310.
- R5: A launch (narrow command-word write or valid wide write) that arrives while msg_valid is 1 is ignored:
  - the message stays unchanged;
  - the stored words stay unchanged;
  - busy_reject is 1 for exactly the following cycle.
- R6: A wide write with wide_idx equal to 0x30 while idle launches a message:
  - the command fields come from bits [31:0] in the R2 positions;
  - msg_dest is bits [63:32];
  - afterwards the two halves read back at offsets 0x300 and 0x310.
- R7: A wide write with any other wide_idx changes nothing: no message, and no change to either readback.
- R8: The command-word readback shows only the stored fields listed in R2 plus bit 12; all other bits read 0. The destination word reads back all 32 bits. Any other offset reads 0.
- R9: If msg_dlv is start-up (3'b110), msg_start_addr equals msg_vector times 4096. For any other delivery mode (fixed 3'b000, INIT 3'b101, and the rest) msg_start_addr is 0.
- R10: When a valid wide write and a narrow write occur in the same cycle, the wide write takes effect and the narrow write is dropped.
- R11: A destination-word write, a write to any other offset, or msg_ready while idle never starts a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Narrow write strobe |
| bus_addr | input | 12 | Narrow byte offset for writes and reads |
| bus_wdata | input | 32 | Narrow write data |
| bus_rdata | output | 32 | Readback of the word at bus_addr |
| wide_wr | input | 1 | Wide write strobe |
| wide_idx | input | 8 | Wide register index |
| wide_wdata | input | 64 | Wide write data, destination in the upper half |
| msg_valid | output | 1 | Message presented, also the busy bit |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv | output | 3 | Delivery mode |
| msg_logical | output | 1 | 1 for logical destination mode |
| msg_level | output | 1 | Level bit |
| msg_trig | output | 1 | Trigger mode, 1 for level |
| msg_shorthand | output | 2 | Destination shorthand, 00 none, 11 all excluding self |
| msg_dest | output | 32 | Destination |
| msg_start_addr | output | 20 | Start address for start-up messages |
| busy_reject | output | 1 | One-cycle pulse after a launch dropped while busy |

## Verification
The assertions check the handshake on every cycle:
- the message holds steady while it waits;
- msg_valid drops after acceptance;
- every launch, accepted or rejected, gives the matching busy or reject outcome;
- the start address is zero for non-start-up modes.

Only the bench scenarios can show the rest:
- that each field lands in its correct bit position across the swept combinations of delivery mode, destination mode, shorthand, level and trigger;
- narrow and wide destination forming;
- readback masking;
- ignored wide indices;
- the wide-over-narrow priority.

// File: rtl/ipi_pkg.sv
// Shared widths, field positions and the message record for the
// interprocessor interrupt command register.
package ipi_pkg;
    localparam int WORD_W     = 32;
    localparam int VEC_W      = 8;
    localparam int DLV_W      = 3;
    localparam int SH_W       = 2;
    localparam int DEST_W     = 32;
    localparam int NDEST_W    = 8;
    localparam int PAGE_SHIFT = 12;
    localparam int START_W    = VEC_W + PAGE_SHIFT;

    // Bit positions inside the command word
    localparam int P_DLV   = 8;
    localparam int P_DM    = 11;
    localparam int P_PEND  = 12;
    localparam int P_LVL   = 14;
    localparam int P_TRIG  = 15;
    localparam int P_SH    = 18;
    localparam int P_NDEST = 24;

    // Bits of the command word that software may store
    localparam logic [WORD_W-1:0] KEEP_MASK =
        (WORD_W'((1 << VEC_W) - 1)) |
        (WORD_W'((1 << DLV_W) - 1) << P_DLV) |
        (WORD_W'(1) << P_DM) |
        (WORD_W'(1) << P_LVL) |
        (WORD_W'(1) << P_TRIG) |
        (WORD_W'((1 << SH_W) - 1) << P_SH);

    typedef enum logic [DLV_W-1:0] {
        DLV_FIXED   = 3'b000,
        DLV_INIT    = 3'b101,
        DLV_STARTUP = 3'b110
    } dlv_e;

    typedef enum logic [SH_W-1:0] {
        SH_NONE     = 2'b00,
        SH_ALL_EXCL = 2'b11
    } shorthand_e;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DLV_W-1:0]   dlv;
        logic               logical;
        logic               level;
        logic               trig;
        logic [SH_W-1:0]    shorthand;
        logic [DEST_W-1:0]  dest;
        logic [START_W-1:0] start_addr;
    } ipi_msg_t;
endpackage

// File: rtl/ipi_addr_decode.sv
// Address decode for the narrow and wide write paths.
// Assumes one narrow access and at most one wide access per cycle.
// A matching wide write wins over a narrow write in the same cycle.
module ipi_addr_decode #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8,
    parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
    parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310,
    parameter logic [IDX_W-1:0]  WIDE_IDX = 8'h30
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wide_wr,
    input  logic [IDX_W-1:0]  wide_idx,
    output logic              sel_low,
    output logic              sel_high,
    output logic              wr_low,
    output logic              wr_high,
    output logic              wr_wide
);
    // Offset and index match, with the wide path taking priority
    always_comb begin
        sel_low  = (bus_addr == LOW_OFS);
        sel_high = (bus_addr == HIGH_OFS);
        wr_wide  = wide_wr && (wide_idx == WIDE_IDX);
        wr_low   = bus_wr && sel_low  && !wr_wide;
        wr_high  = bus_wr && sel_high && !wr_wide;
    end
endmodule

// File: rtl/ipi_msg_former.sv
// Builds a message record from a command word and a destination.
// Purely combinational.
// Reserved command bits are ignored.
module ipi_msg_former
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [DEST_W-1:0] dest,
    output ipi_msg_t          msg
);
    logic unused_cmd_bits;

    // Field extraction and start-address derivation
    always_comb begin
        msg.vector     = cmd_word[VEC_W-1:0];
        msg.dlv        = cmd_word[P_DLV +: DLV_W];
        msg.logical    = cmd_word[P_DM];
        msg.level      = cmd_word[P_LVL];
        msg.trig       = cmd_word[P_TRIG];
        msg.shorthand  = cmd_word[P_SH +: SH_W];
        msg.dest       = dest;
        msg.start_addr = (cmd_word[P_DLV +: DLV_W] == DLV_STARTUP)
                       ? {cmd_word[VEC_W-1:0], {PAGE_SHIFT{1'b0}}}
                       : '0;
    end

    assign unused_cmd_bits = ^(cmd_word & ~KEEP_MASK);
endmodule

// File: rtl/ipi_cmd_state.sv
// Stored command words, the in-flight message snapshot, the pending flag
// and the reject pulse.
// Assumes at most one launch strobe per cycle; the decode guarantees this.
module ipi_cmd_state
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_low,
    input  logic              wr_high,
    input  logic              wr_wide,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [2*WORD_W-1:0] wide_wdata,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] low_reg,
    output logic [WORD_W-1:0] high_reg,
    output logic              pending,
    output logic              reject,
    output ipi_msg_t          msg_q
);
    logic              launch_req;
    logic              launch_ok;
    logic [WORD_W-1:0] new_low;
    logic [DEST_W-1:0] new_dest;
    ipi_msg_t          formed;

    // Select the command word and destination of the incoming launch
    always_comb begin
        launch_req = wr_low || wr_wide;
        launch_ok  = launch_req && !pending;
        new_low    = wr_wide ? wide_wdata[WORD_W-1:0] : bus_wdata;
        new_dest   = wr_wide ? wide_wdata[2*WORD_W-1:WORD_W]
                             : DEST_W'(high_reg[P_NDEST +: NDEST_W]);
    end

    ipi_msg_former u_former (
        .cmd_word (new_low),
        .dest     (new_dest),
        .msg      (formed)
    );

    // Pending flag and message snapshot taken at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            msg_q   <= '0;
        end else if (launch_ok) begin
            pending <= 1'b1;
            msg_q   <= formed;
        end else if (pending && msg_ready) begin
            pending <= 1'b0;
        end
    end

    // Software-visible command and destination words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_reg  <= '0;
            high_reg <= '0;
        end else begin
            if (launch_ok)
                low_reg <= new_low & KEEP_MASK;
            if (wr_wide && !pending)
                high_reg <= wide_wdata[2*WORD_W-1:WORD_W];
            else if (wr_high)
                high_reg <= bus_wdata;
        end
    end

    // One-cycle pulse for a launch dropped while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            reject <= 1'b0;
        else
            reject <= launch_req && pending;
    end
endmodule

// File: rtl/ipi_cmd_reg.sv
// Interprocessor interrupt command register, top level.
// The narrow port writes and reads 32-bit words at byte offsets.
// The wide port writes the full 64-bit command at one register index.
// The message record leaves on a valid/ready interface.
// msg_valid doubles as the busy bit.
module ipi_cmd_reg
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8,
    parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
    parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 wide_wr,
    input  logic [IDX_W-1:0]     wide_idx,
    input  logic [2*WORD_W-1:0]  wide_wdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [VEC_W-1:0]     msg_vector,
    output logic [DLV_W-1:0]     msg_dlv,
    output logic                 msg_logical,
    output logic                 msg_level,
    output logic                 msg_trig,
    output logic [SH_W-1:0]      msg_shorthand,
    output logic [DEST_W-1:0]    msg_dest,
    output logic [START_W-1:0]   msg_start_addr,
    output logic                 busy_reject
);
    localparam logic [IDX_W-1:0] WIDE_IDX = IDX_W'(LOW_OFS >> 4);

    logic              sel_low, sel_high;
    logic              wr_low, wr_high, wr_wide;
    logic              wr_launch;
    logic              pending;
    logic [WORD_W-1:0] low_reg, high_reg;
    ipi_msg_t          msg_q;

    ipi_addr_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS),
        .WIDE_IDX (WIDE_IDX)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wide_wr  (wide_wr),
        .wide_idx (wide_idx),
        .sel_low  (sel_low),
        .sel_high (sel_high),
        .wr_low   (wr_low),
        .wr_high  (wr_high),
        .wr_wide  (wr_wide)
    );

    assign wr_launch = wr_low || wr_wide;

    ipi_cmd_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_low     (wr_low),
        .wr_high    (wr_high),
        .wr_wide    (wr_wide),
        .bus_wdata  (bus_wdata),
        .wide_wdata (wide_wdata),
        .msg_ready  (msg_ready),
        .low_reg    (low_reg),
        .high_reg   (high_reg),
        .pending    (pending),
        .reject     (busy_reject),
        .msg_q      (msg_q)
    );

    // Readback multiplexer with the busy bit merged into the command word
    always_comb begin
        if (sel_low)
            bus_rdata = low_reg | (WORD_W'(pending) << P_PEND);
        else if (sel_high)
            bus_rdata = high_reg;
        else
            bus_rdata = '0;
    end

    // Message record onto the output ports
    always_comb begin
        msg_valid      = pending;
        msg_vector     = msg_q.vector;
        msg_dlv        = msg_q.dlv;
        msg_logical    = msg_q.logical;
        msg_level      = msg_q.level;
        msg_trig       = msg_q.trig;
        msg_shorthand  = msg_q.shorthand;
        msg_dest       = msg_q.dest;
        msg_start_addr = msg_q.start_addr;
    end
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
// Protocol checker for ipi_cmd_reg, attached with bind.
// Observes the handshake and the launch strobe only; drives nothing.
module ipi_cmd_reg_chk
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LOW_OFS = 12'h300
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_launch,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [VEC_W-1:0]    msg_vector,
    input logic [DLV_W-1:0]    msg_dlv,
    input logic                msg_logical,
    input logic                msg_level,
    input logic                msg_trig,
    input logic [SH_W-1:0]     msg_shorthand,
    input logic [DEST_W-1:0]   msg_dest,
    input logic [START_W-1:0]  msg_start_addr,
    input logic                busy_reject,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_rdata
);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid &&
        $stable({msg_vector, msg_dlv, msg_logical, msg_level, msg_trig,
                 msg_shorthand, msg_dest, msg_start_addr}));

    p_accept_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_launch && !msg_valid |=> msg_valid && !busy_reject);

    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_launch && msg_valid |=> busy_reject);

    p_no_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_launch && msg_valid) |=> !busy_reject);

    p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && !wr_launch |=> !msg_valid);

    p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_dlv != DLV_STARTUP) |-> msg_start_addr == '0);

    p_resv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == LOW_OFS) |-> ((bus_rdata & ~(KEEP_MASK | (WORD_W'(1) << P_PEND))) == '0));
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
    .ADDR_W  (ADDR_W),
    .LOW_OFS (LOW_OFS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_launch      (wr_launch),
    .msg_valid      (msg_valid),
    .msg_ready      (msg_ready),
    .msg_vector     (msg_vector),
    .msg_dlv        (msg_dlv),
    .msg_logical    (msg_logical),
    .msg_level      (msg_level),
    .msg_trig       (msg_trig),
    .msg_shorthand  (msg_shorthand),
    .msg_dest       (msg_dest),
    .msg_start_addr (msg_start_addr),
    .busy_reject    (busy_reject),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata)
);

// File: tb/ipi_cmd_reg_test.sv
module ipi_cmd_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wide_wr = 1'b0;
    logic [7:0]  wide_idx = 8'h0;
    logic [63:0] wide_wdata = 64'h0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dlv;
    logic        msg_logical, msg_level, msg_trig;
    logic [1:0]  msg_shorthand;
    logic [31:0] msg_dest;
    logic [19:0] msg_start_addr;
    logic        busy_reject;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] KEEP = 32'h000C_CFFF;

    always #2.5 clk = ~clk;

    ipi_cmd_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wide_wr(wide_wr),
        .wide_idx(wide_idx), .wide_wdata(wide_wdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dlv(msg_dlv),
        .msg_logical(msg_logical), .msg_level(msg_level), .msg_trig(msg_trig),
        .msg_shorthand(msg_shorthand), .msg_dest(msg_dest),
        .msg_start_addr(msg_start_addr), .busy_reject(busy_reject)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic nwrite(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wwrite(input logic [7:0] idx, input logic [63:0] d);
        wide_wr = 1'b1; wide_idx = idx; wide_wdata = d;
        step();
        wide_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        step();
        msg_ready = 1'b0;
    endtask

    // Compare every message field against a command word and destination
    task automatic chk_msg(input string tag, input logic [31:0] lo, input logic [31:0] dst);
        logic [19:0] sa;
        sa = (lo[10:8] == 3'b110) ? {lo[7:0], 12'h000} : 20'h0;
        chk({tag, " valid"}, msg_valid, 1);
        chk({tag, " vector"}, msg_vector, lo[7:0]);
        chk({tag, " dlv"}, msg_dlv, lo[10:8]);
        chk({tag, " logical"}, msg_logical, lo[11]);
        chk({tag, " level"}, msg_level, lo[14]);
        chk({tag, " trig"}, msg_trig, lo[15]);
        chk({tag, " shorthand"}, msg_shorthand, lo[19:18]);
        chk({tag, " dest"}, msg_dest, dst);
        chk("R9 start address", msg_start_addr, sa);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] lo;
        logic [31:0] d8;
        logic [31:0] hw;
        logic [31:0] dw;

        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 valid", msg_valid, 0);
        chk("R1 reject", busy_reject, 0);
        rd(12'h300, r); chk("R1 low read", r, 0);
        rd(12'h310, r); chk("R1 high read", r, 0);

        // R11 no launch from destination write, other offsets, or ready
        nwrite(12'h310, 32'h1234_5678);
        chk("R11 high write no launch", msg_valid, 0);
        nwrite(12'h320, 32'hFFFF_FFFF);
        chk("R11 other offset no launch", msg_valid, 0);
        msg_ready = 1'b1; step(); msg_ready = 1'b0;
        chk("R11 ready idle", msg_valid, 0);
        rd(12'h320, r); chk("R8 other offset reads 0", r, 0);
        rd(12'h310, r); chk("R8 high full readback", r, 32'h1234_5678);
        rd(12'h300, r); chk("R11 low unchanged", r, 0);

        // Narrow sweep over every delivery mode, destination mode, shorthand, level
        for (int c = 0; c < 128; c++) begin
            lo = ((c * 37 + 5) % 256) | ((c & 7) << 8) | (((c >> 3) & 1) << 11)
               | (((c >> 6) & 1) << 14) | ((((c >> 0) ^ (c >> 3)) & 1) << 15)
               | (((c >> 4) & 3) << 18);
            if (c & 2) lo = lo | 32'h0200_3000;   // reserved and busy bits set
            d8 = (c * 11 + 3) % 256;
            hw = (d8 << 24) | 32'h00A5_5A00 | c;
            nwrite(12'h310, hw);
            nwrite(12'h300, lo);
            chk_msg("R2 narrow launch", lo, d8);
            rd(12'h300, r);
            chk("R3 busy bit set", r[12], 1);
            chk("R8 low masked readback", r, (lo & KEEP) | 32'h1000);
            if (c % 4 == 0) begin
                nwrite(12'h310, 32'hEE00_0000);
                chk_msg("R4 hold while waiting", lo, d8);
                rd(12'h310, r); chk("R4 high rewritten", r, 32'hEE00_0000);
            end
            if (c % 8 == 1) begin
                nwrite(12'h300, ~lo);
                chk("R5 reject pulse", busy_reject, 1);
                chk_msg("R5 message unchanged", lo, d8);
                rd(12'h300, r); chk("R5 low unchanged", r, (lo & KEEP) | 32'h1000);
                step();
                chk("R5 pulse one cycle", busy_reject, 0);
            end
            accept();
            chk("R3 cleared after accept", msg_valid, 0);
            rd(12'h300, r); chk("R3 busy bit clear", r, lo & KEEP);
        end

        // Wide sweep with 32-bit destinations
        for (int c = 0; c < 32; c++) begin
            lo = ((c * 53 + 1) % 256) | ((c & 7) << 8) | (((c >> 3) & 1) << 11)
               | (((c >> 4) & 1) << 15) | (((c >> 1) & 3) << 18) | 32'hFF00_0000;
            dw = 32'h1000_0001 * (c + 1) + 32'h00C0_FFEE;
            wwrite(8'h30, {dw, lo});
            chk_msg("R6 wide launch", lo, dw);
            rd(12'h310, r); chk("R6 high readback", r, dw);
            rd(12'h300, r); chk("R6 low readback", r, (lo & KEEP) | 32'h1000);
            if (c % 4 == 2) begin
                wwrite(8'h30, ~{dw, lo});
                chk("R5 wide reject pulse", busy_reject, 1);
                chk_msg("R5 wide message unchanged", lo, dw);
                rd(12'h310, r); chk("R5 wide high unchanged", r, dw);
            end
            accept();
            chk("R3 wide cleared", msg_valid, 0);
        end

        // R7 wide write at an unmatched index
        rd(12'h310, hw);
        rd(12'h300, lo);
        wwrite(8'h31, 64'hDEAD_BEEF_0000_0605);
        chk("R7 no launch", msg_valid, 0);
        rd(12'h310, r); chk("R7 high unchanged", r, hw);
        rd(12'h300, r); chk("R7 low unchanged", r, lo);

        // R10 wide and narrow in the same cycle
        wide_wr = 1'b1; wide_idx = 8'h30; wide_wdata = 64'hCAFE_0001_0000_0642;
        bus_wr = 1'b1; bus_addr = 12'h300; bus_wdata = 32'h0000_0011;
        step();
        wide_wr = 1'b0; bus_wr = 1'b0;
        chk_msg("R10 wide wins", 32'h0000_0642, 32'hCAFE_0001);
        chk("R10 no reject", busy_reject, 0);
        accept();
        wide_wr = 1'b1; wide_idx = 8'h30; wide_wdata = 64'h0BAD_0002_0000_0500;
        bus_wr = 1'b1; bus_addr = 12'h310; bus_wdata = 32'h7700_0000;
        step();
        wide_wr = 1'b0; bus_wr = 1'b0;
        rd(12'h310, r); chk("R10 narrow high dropped", r, 32'h0BAD_0002);
        chk_msg("R10 wide second", 32'h0000_0500, 32'h0BAD_0002);
        accept();

        // R9 start-up page 0x08 gives 0x8000
        nwrite(12'h310, 32'h0300_0000);
        nwrite(12'h300, 32'h000C_0608);
        chk("R9 startup 0x08", msg_start_addr, 20'h08000);
        chk("R2 shorthand all-excl", msg_shorthand, 2'b11);
        accept();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule